// File: doc/BRIEF.md
# Trim Calibration Sequencer

This block runs the automatic calibration of a timing-measurement front end. The front end has four trim codes, and each code acts on one analog element. The analog trim elements and the comparator are outside this block. The block reaches them only through four code outputs, a measurement-select output and a single comparator bit. The comparator bit is high when the measured output sits above its reference level.

Software writes a start bit to launch a calibration. The sequencer then calibrates the four trims one after another in a fixed order:

1. Offset cancellation.
2. Clock pulse width.
3. Data rising-edge delay.
4. Data falling-edge delay.

Each trim is found by a 6-bit successive approximation that begins at mid-scale. For each bit, the block applies a trial code, waits a programmable settle count, and then takes one comparator sample.

When the run completes, the start bit clears itself, the results are kept as the retained set, and an open-drain done monitor starts to pull low. A bypass input routes the raw signals to the comparator. Bypass is suppressed while a run is in progress, so a run launched together with bypass still calibrates, and the bypass takes effect once the run finishes. Sleep forces the trim outputs to zero. Sleep also aborts any run in progress. On wake, the trims from the last completed calibration come back.

Top module: `trimcal_seq`

## Requirements
- R1: After synchronous reset, every trim output equals mid-scale 32. `start_bit`, `busy` and `mon_oe` are 0, and `meas_sel` is 0.
- R2: A one-cycle `start_set` pulse makes `start_bit` 1 after the next clock edge. If sleep is low, the run launches on the following edge. `start_bit` stays 1 for the whole run and returns to 0 when the run ends. A `start_set` pulse during a run does not cause a second run.
- R3: While `busy` is high, `meas_sel` steps through 0 (offset), 1 (duty), 2 (rising delay) and 3 (falling delay), in that order and never backwards. The run lasts exactly 24*(`settle_cfg`+1) cycles.
- R4: Each trim is found by successive approximation, most significant bit first, starting from trial code 32. A sample with `cmp_hi`=1 clears the trial bit. A sample with `cmp_hi`=0 keeps it. The next lower bit is then set for the next trial. If the comparator reports high exactly when the code exceeds a target T, the final code is T.
- R5: Each trial code is held for `settle_cfg`+1 cycles, and the comparator is sampled in the last of those cycles. For example, the offset trim reads 32 for the first `settle_cfg`+1 busy cycles and then reads 48 or 16.
- R6: During a run, only the trim selected by `meas_sel` changes. Trims of earlier steps hold their new results, and trims of later steps hold their values from before the run.
- R7: `mon_oe` is 0 from reset until the first completed run and throughout every run. It becomes 1 when a run completes. `mon_dat` is always 0.
- R8: `path_raw` follows `bypass_in` while the block is idle and is 0 while a run is in progress. A run launched with bypass high still calibrates and stores its results.
- R9: While `sleep_in` is high, all trim outputs read 0 and no run launches, although `start_set` is still recorded. After wake, the trims equal the last completed results and a pending start launches.
- R10: Raising `sleep_in` during a run ends the run after the next edge and clears `start_bit`. `mon_oe` stays 0, and after wake the trims equal the results of the previous completed run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| start_set | input | 1 | Write pulse that sets the start bit |
| bypass_in | input | 1 | Bypass bit: feed raw signals to the comparator |
| sleep_in | input | 1 | Sleep bit |
| settle_cfg | input | 4 | Settle cycles before each comparator sample |
| cmp_hi | input | 1 | Comparator: measured output above reference |
| start_bit | output | 1 | Start bit, self-clearing |
| busy | output | 1 | Calibration run in progress |
| meas_sel | output | 2 | Measurement configuration: 0 offset, 1 duty, 2 rise, 3 fall |
| trim_ofs | output | 6 | Offset trim code |
| trim_duty | output | 6 | Clock duty trim code |
| trim_rise | output | 6 | Data rising-edge delay trim code |
| trim_fall | output | 6 | Data falling-edge delay trim code |
| path_raw | output | 1 | Raw inputs routed to the comparator |
| mon_oe | output | 1 | Done monitor output enable (open drain pulls low) |
| mon_dat | output | 1 | Done monitor data, constant low |

## Verification
On every cycle, the assertions check the following:
- `start_bit` covers every busy cycle and clears when a run ends.
- The monitor and the bypass path stay released during a run.
- The measurement step never moves backwards.
- A trim outside the current step does not move.
- Sleep ends a run.

Only the bench's scenarios can show the calibrated values themselves. The bench sweeps all 64 target codes on every lane at three settle counts, and also checks the exact run length, the timing of the first trial, restoration after wake, and the abort path mid-run.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;

    localparam int unsigned LANES = 4;

    // Calibration order; the encoding is also the measurement select value.
    typedef enum logic [1:0] {
        STEP_OFS  = 2'd0,
        STEP_DUTY = 2'd1,
        STEP_RISE = 2'd2,
        STEP_FALL = 2'd3
    } step_e;

    // Events the sequencer hands to the trim bank each cycle.
    typedef struct packed {
        logic  launch;
        logic  smp;
        logic  finish;
        step_e step;
    } ctl_s;

    function automatic logic is_last_step(input step_e s);
        return s == STEP_FALL;
    endfunction

endpackage

// File: rtl/trimcal_timer.sv
module trimcal_timer #(
    parameter int unsigned SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic [SETTLE_W-1:0] limit,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/trimcal_fsm.sv
module trimcal_fsm
    import trimcal_pkg::*;
#(
    parameter int unsigned CODE_W = 6,
    localparam int unsigned BIT_W = $clog2(CODE_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_set,
    input  logic             sleep_in,
    input  logic             tmr_done,
    output ctl_s             ctl,
    output logic [BIT_W-1:0] bit_idx,
    output logic             tmr_clr,
    output logic             running,
    output logic             start_q,
    output logic             cal_done
);
    step_e step_q;
    logic  launch, smp, finish, abort;

    assign launch  = !running && start_q && !sleep_in;
    assign smp     = running && tmr_done && !sleep_in;
    assign abort   = running && sleep_in;
    assign finish  = smp && (bit_idx == '0) && is_last_step(step_q);
    assign tmr_clr = !running || smp;

    assign ctl.launch = launch;
    assign ctl.smp    = smp;
    assign ctl.finish = finish;
    assign ctl.step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            start_q  <= 1'b0;
            cal_done <= 1'b0;
            step_q   <= STEP_OFS;
            bit_idx  <= BIT_W'(CODE_W - 1);
        end else begin
            if (finish || abort) begin
                start_q <= 1'b0;
            end else if (start_set) begin
                start_q <= 1'b1;
            end

            if (abort) begin
                running <= 1'b0;
            end else if (launch) begin
                running  <= 1'b1;
                cal_done <= 1'b0;
                step_q   <= STEP_OFS;
                bit_idx  <= BIT_W'(CODE_W - 1);
            end else if (smp) begin
                if (bit_idx == '0) begin
                    if (is_last_step(step_q)) begin
                        running  <= 1'b0;
                        cal_done <= 1'b1;
                    end else begin
                        step_q  <= step_e'(step_q + 2'd1);
                        bit_idx <= BIT_W'(CODE_W - 1);
                    end
                end else begin
                    bit_idx <= bit_idx - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/trimcal_bank.sv
module trimcal_bank
    import trimcal_pkg::*;
#(
    parameter int unsigned CODE_W = 6,
    localparam int unsigned BIT_W = $clog2(CODE_W)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  ctl_s                               ctl,
    input  logic [BIT_W-1:0]                   bit_idx,
    input  logic                               cmp_hi,
    input  logic                               sleep_in,
    output logic [LANES-1:0][CODE_W-1:0]       trim_o
);
    localparam logic [CODE_W-1:0] CENTER = CODE_W'(1) << (CODE_W - 1);

    logic [CODE_W-1:0] trial_bit, next_bit;

    assign trial_bit = CODE_W'(1) << bit_idx;
    assign next_bit  = trial_bit >> 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [CODE_W-1:0] work, keep, nxt;
        logic              own, enter;

        assign own = ctl.smp && (ctl.step == step_e'(g));

        if (g == 0) begin : g_first
            assign enter = ctl.launch;
        end else begin : g_rest
            assign enter = ctl.smp && (bit_idx == '0) && (ctl.step == step_e'(g - 1));
        end

        always_comb begin
            nxt = work;
            if (sleep_in) begin
                nxt = keep;
            end else if (enter) begin
                nxt = CENTER;
            end else if (own) begin
                nxt = (cmp_hi ? (work & ~trial_bit) : work) | next_bit;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                work <= CENTER;
                keep <= CENTER;
            end else begin
                work <= nxt;
                if (ctl.finish) begin
                    keep <= nxt;
                end
            end
        end

        assign trim_o[g] = sleep_in ? '0 : work;
    end
endmodule

// File: rtl/trimcal_seq.sv
module trimcal_seq
    import trimcal_pkg::*;
#(
    parameter int unsigned CODE_W   = 6,
    parameter int unsigned SETTLE_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_set,
    input  logic                bypass_in,
    input  logic                sleep_in,
    input  logic [SETTLE_W-1:0] settle_cfg,
    input  logic                cmp_hi,
    output logic                start_bit,
    output logic                busy,
    output logic [1:0]          meas_sel,
    output logic [CODE_W-1:0]   trim_ofs,
    output logic [CODE_W-1:0]   trim_duty,
    output logic [CODE_W-1:0]   trim_rise,
    output logic [CODE_W-1:0]   trim_fall,
    output logic                path_raw,
    output logic                mon_oe,
    output logic                mon_dat
);
    localparam int unsigned BIT_W = $clog2(CODE_W);

    ctl_s                         ctl;
    logic [BIT_W-1:0]             bit_idx;
    logic                         tmr_clr, tmr_done, running, start_q, cal_done;
    logic [LANES-1:0][CODE_W-1:0] trims;

    trimcal_timer #(.SETTLE_W(SETTLE_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (tmr_clr),
        .limit (settle_cfg),
        .done  (tmr_done)
    );

    trimcal_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_set (start_set),
        .sleep_in  (sleep_in),
        .tmr_done  (tmr_done),
        .ctl       (ctl),
        .bit_idx   (bit_idx),
        .tmr_clr   (tmr_clr),
        .running   (running),
        .start_q   (start_q),
        .cal_done  (cal_done)
    );

    trimcal_bank #(.CODE_W(CODE_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .bit_idx  (bit_idx),
        .cmp_hi   (cmp_hi),
        .sleep_in (sleep_in),
        .trim_o   (trims)
    );

    assign start_bit = start_q;
    assign busy      = running;
    assign meas_sel  = running ? ctl.step : STEP_OFS;
    assign trim_ofs  = trims[STEP_OFS];
    assign trim_duty = trims[STEP_DUTY];
    assign trim_rise = trims[STEP_RISE];
    assign trim_fall = trims[STEP_FALL];
    assign path_raw  = bypass_in && !running;
    assign mon_oe    = cal_done;
    assign mon_dat   = 1'b0;
endmodule

// File: rtl/trimcal_seq_chk.sv
module trimcal_seq_chk #(
    parameter int unsigned CODE_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_in,
    input logic              start_bit,
    input logic              busy,
    input logic [1:0]        meas_sel,
    input logic [CODE_W-1:0] trim_ofs,
    input logic [CODE_W-1:0] trim_fall,
    input logic              path_raw,
    input logic              mon_oe
);
    assert_busy_has_start_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> start_bit);

    assert_end_clears_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !start_bit);

    assert_step_forward_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (meas_sel >= $past(meas_sel)));

    assert_ofs_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !sleep_in && !$past(sleep_in)
         && meas_sel != 2'd0 && $past(meas_sel) != 2'd0) |-> $stable(trim_ofs));

    assert_fall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !sleep_in && !$past(sleep_in)
         && meas_sel != 2'd3 && $past(meas_sel) != 2'd3) |-> $stable(trim_fall));

    assert_mon_released_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mon_oe);

    assert_mon_on_finish_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(sleep_in)) |-> mon_oe);

    assert_no_raw_in_run_R8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !path_raw);

    assert_sleep_aborts_R10: assert property (@(posedge clk) disable iff (rst)
        sleep_in |=> !busy);
endmodule

bind trimcal_seq trimcal_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_in  (sleep_in),
    .start_bit (start_bit),
    .busy      (busy),
    .meas_sel  (meas_sel),
    .trim_ofs  (trim_ofs),
    .trim_fall (trim_fall),
    .path_raw  (path_raw),
    .mon_oe    (mon_oe)
);

// File: tb/trimcal_seq_bench.sv
module trimcal_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_set = 1'b0, bypass_in = 1'b0, sleep_in = 1'b0;
    logic [3:0] settle_cfg = 4'd0;
    logic       cmp_hi;
    logic       start_bit, busy, path_raw, mon_oe, mon_dat;
    logic [1:0] meas_sel;
    logic [5:0] trim_ofs, trim_duty, trim_rise, trim_fall;

    logic [5:0] tgt [4];
    logic [5:0] sel_code;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    trimcal_seq u_trimcal_seq (
        .clk(clk), .rst(rst), .start_set(start_set), .bypass_in(bypass_in),
        .sleep_in(sleep_in), .settle_cfg(settle_cfg), .cmp_hi(cmp_hi),
        .start_bit(start_bit), .busy(busy), .meas_sel(meas_sel),
        .trim_ofs(trim_ofs), .trim_duty(trim_duty), .trim_rise(trim_rise),
        .trim_fall(trim_fall), .path_raw(path_raw), .mon_oe(mon_oe), .mon_dat(mon_dat)
    );

    // Comparator model: measured output above reference when code exceeds target.
    always_comb begin
        case (meas_sel)
            2'd0: sel_code = trim_ofs;
            2'd1: sel_code = trim_duty;
            2'd2: sel_code = trim_rise;
            default: sel_code = trim_fall;
        endcase
    end
    assign cmp_hi = sel_code > tgt[meas_sel];

    function automatic logic [5:0] lane(input int l);
        case (l)
            0: return trim_ofs;
            1: return trim_duty;
            2: return trim_rise;
            default: return trim_fall;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cal(input logic [5:0] a, input logic [5:0] b, input logic [5:0] c,
                           input logic [5:0] d, input int s, input logic byp);
        logic [5:0] prev [4];
        int bsy = 0, lane_bad = 0, order_bad = 0, trial_bad = 0, raw_bad = 0;
        int last_sel = 0, guard = 0;
        logic [5:0] second;
        tgt[0] = a; tgt[1] = b; tgt[2] = c; tgt[3] = d;
        settle_cfg = 4'(s);
        bypass_in = byp;
        for (int l = 0; l < 4; l++) prev[l] = lane(l);
        second = (a >= 6'd32) ? 6'd48 : 6'd16;
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        check(start_bit == 1'b1 && busy == 1'b0, "R2 start bit set before launch", start_bit, 1);
        while (guard < 2000) begin
            @(negedge clk);
            guard++;
            if (busy) begin
                bsy++;
                if (!start_bit) lane_bad++;
                if (int'(meas_sel) < last_sel) order_bad++;
                last_sel = int'(meas_sel);
                for (int l = 0; l < 4; l++) begin
                    if (l < int'(meas_sel) && lane(l) != tgt[l]) lane_bad++;
                    if (l > int'(meas_sel) && lane(l) != prev[l]) lane_bad++;
                end
                if (bsy <= s + 1 && trim_ofs != 6'd32) trial_bad++;
                if (bsy == s + 2 && trim_ofs != second) trial_bad++;
                if (path_raw) raw_bad++;
                if (mon_oe) raw_bad++;
            end else if (bsy > 0) begin
                break;
            end
        end
        check(bsy == 24 * (s + 1), "R3 run length", bsy, 24 * (s + 1));
        check(order_bad == 0 && last_sel == 3, "R3 step order", order_bad, 0);
        check(lane_bad == 0, "R6 unselected trims held", lane_bad, 0);
        check(trial_bad == 0, "R5 first trial timing", trial_bad, 0);
        check(raw_bad == 0, "R7 R8 released during run", raw_bad, 0);
        for (int l = 0; l < 4; l++)
            check(lane(l) == tgt[l], "R4 trim result", lane(l), tgt[l]);
        check(start_bit == 1'b0, "R2 start bit self clears", start_bit, 0);
        check(mon_oe == 1'b1 && mon_dat == 1'b0, "R7 monitor pulls low", mon_oe, 1);
        check(path_raw == byp, "R8 bypass after run", path_raw, byp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int l = 0; l < 4; l++) tgt[l] = 6'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int l = 0; l < 4; l++) check(lane(l) == 6'd32, "R1 trim centered", lane(l), 32);
        check(start_bit == 0 && busy == 0, "R1 idle after reset", busy, 0);
        check(mon_oe == 0 && meas_sel == 0, "R1 R7 monitor released", mon_oe, 0);
        bypass_in = 1'b1;
        #1 check(path_raw == 1'b1, "R8 bypass while idle", path_raw, 1);
        bypass_in = 1'b0;

        // Near-exhaustive sweep of target codes on every lane
        for (int v = 0; v < 64; v++)
            run_cal(6'(v), 6'(63 - v), 6'((v * 5 + 7) % 64), 6'((v * 11 + 3) % 64), v % 3, 1'b0);

        // R8: launched together with bypass
        run_cal(6'd10, 6'd20, 6'd30, 6'd40, 1, 1'b1);
        bypass_in = 1'b0;

        // R2: extra start pulse during a run gives no second run
        fork
            run_cal(6'd33, 6'd1, 6'd62, 6'd17, 2, 1'b0);
            begin
                repeat (20) @(negedge clk);
                start_set = 1'b1;
                @(negedge clk) start_set = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && start_bit == 1'b0, "R2 no relaunch from pulse in run", busy, 0);

        // R9: sleep while idle, start recorded but held off
        @(negedge clk) sleep_in = 1'b1;
        #1 check(trim_ofs == 0 && trim_duty == 0 && trim_rise == 0 && trim_fall == 0,
                 "R9 trims zero in sleep", trim_ofs, 0);
        start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        repeat (4) @(negedge clk);
        check(start_bit == 1'b1 && busy == 1'b0, "R9 no launch while asleep", busy, 0);
        sleep_in = 1'b0;
        #1 check(trim_ofs == 6'd33 && trim_duty == 6'd1 && trim_rise == 6'd62 && trim_fall == 6'd17,
                 "R9 trims restored on wake", trim_rise, 62);
        @(negedge clk);
        check(busy == 1'b1, "R9 pending start launches after wake", busy, 1);
        tgt[0] = 6'd5; tgt[1] = 6'd6; tgt[2] = 6'd7; tgt[3] = 6'd8;
        while (busy) @(negedge clk);
        check(trim_ofs == 6'd5 && trim_fall == 6'd8, "R9 run after wake completes", trim_fall, 8);

        // R10: sleep in the middle of a run
        tgt[0] = 6'd50; tgt[1] = 6'd51; tgt[2] = 6'd52; tgt[3] = 6'd53;
        settle_cfg = 4'd1;
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
        repeat (20) @(negedge clk);
        check(busy == 1'b1 && meas_sel == 2'd1, "R10 run in progress", meas_sel, 1);
        sleep_in = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && start_bit == 1'b0, "R10 run aborted", start_bit, 0);
        check(mon_oe == 1'b0, "R10 monitor stays released", mon_oe, 0);
        sleep_in = 1'b0;
        #1 check(trim_ofs == 6'd5 && trim_duty == 6'd6 && trim_rise == 6'd7 && trim_fall == 6'd8,
                 "R10 previous results restored", trim_ofs, 5);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && trim_duty == 6'd6, "R10 stays idle", busy, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule